// File: doc/BRIEF.md
# Integer Decode and Execute Stage

This block is the purely combinational heart of a small 32-bit integer pipeline stage. It receives one fetched instruction word together with the two source register values already read for it. It works out which register-to-register or register-to-immediate operation the word encodes and computes the 32-bit result. It also reports which destination register receives the result and whether a write should happen at all.

The block covers add and subtract without overflow traps, the bitwise OR, XOR and NOR forms, constant shifts, immediate add, immediate AND and OR, and the load-upper-immediate form. It has no state. The register file, the program counter and all memory and control-flow instructions stay outside it. An encoding it does not know is reported on an illegal flag, and in that case no write is requested. A surrounding stage uses the flag to raise an exception and relies on the suppressed write so that no architectural state changes.

Top module: `mdx_exec_unit`

## Requirements
- R1: With opcode [31:26] = 0, func [5:0] = 0x21 gives rs + rt and func 0x23 gives rs - rt, both modulo 2^32 with no overflow indication.
- R2: With opcode 0, func 0x25 gives rs | rt, func 0x26 gives rs ^ rt and func 0x27 gives ~(rs | rt).
- R3: With opcode 0, func 0x00 shifts rt left, func 0x02 shifts rt right with zero fill and func 0x03 shifts rt right with sign fill. The distance is the shamt field [10:6], and the rs value has no effect. A distance of 0 returns rt unchanged.
- R4: Opcode 0x09 gives rs plus the 16-bit immediate [15:0], sign-extended to 32 bits, modulo 2^32.
- R5: Opcode 0x0C gives rs & zero_extend(imm) and opcode 0x0D gives rs | zero_extend(imm).
- R6: Opcode 0x0F gives imm << 16 with the low 16 bits zero, and the rs value has no effect.
- R7: For a recognized encoding, write enable is 1 and the illegal flag is 0. The destination index is [15:11] when the opcode is 0, and [20:16] for the immediate opcodes.
- R8: Any other opcode, or opcode 0 with any other func, gives write enable 0 and illegal 1, with result 0 and destination index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| src_a_i | input | DATA_W | Value of the register named by [25:21] |
| src_b_i | input | DATA_W | Value of the register named by [20:16] |
| result_o | output | DATA_W | Computed result |
| dest_idx_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Result should be written |
| illegal_o | output | 1 | Encoding not recognized |

## Verification
The bench builds the block with its default DATA_W of 32, so the shamt field reaches every shift distance from 0 to 31. At that width the sign bit of both the operand and the immediate sits at the positions the encoding fixes. Directed words cover the shift distances 0 and 31 and immediates with bit 15 set and clear. They also cover add and subtract wrap-around, and opcodes and func values next to the legal ones. A long run of random words over all legal and several illegal encodings is then compared against a behavioural model.

// File: rtl/mdx_pkg.sv
package mdx_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam int SHAMT_W = 5;
  localparam int IMM_W   = 16;
  localparam int OPC_W   = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;

  typedef enum logic [3:0] {
    XOP_NONE, XOP_ADD, XOP_SUB, XOP_AND, XOP_OR, XOP_XOR, XOP_NOR,
    XOP_SLL, XOP_SRL, XOP_SRA, XOP_LUI
  } xop_e;

  typedef struct packed {
    xop_e op;
    logic use_imm;
    logic imm_signed;
    logic dest_is_rd;
    logic legal;
  } xctrl_t;
endpackage

// File: rtl/mdx_decoder.sv
module mdx_decoder
  import mdx_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [5:0]       fn_i,
  output xctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o = '{op: XOP_NONE, use_imm: 1'b0, imm_signed: 1'b0,
               dest_is_rd: 1'b0, legal: 1'b0};
    unique case (opc_i)
      OPC_REG: begin
        ctrl_o.dest_is_rd = 1'b1;
        ctrl_o.legal      = 1'b1;
        case (fn_i)
          FN_ADDU: ctrl_o.op = XOP_ADD;
          FN_SUBU: ctrl_o.op = XOP_SUB;
          FN_OR:   ctrl_o.op = XOP_OR;
          FN_XOR:  ctrl_o.op = XOP_XOR;
          FN_NOR:  ctrl_o.op = XOP_NOR;
          FN_SLL:  ctrl_o.op = XOP_SLL;
          FN_SRL:  ctrl_o.op = XOP_SRL;
          FN_SRA:  ctrl_o.op = XOP_SRA;
          default: begin
            ctrl_o.legal      = 1'b0;
            ctrl_o.dest_is_rd = 1'b0;
          end
        endcase
      end
      OPC_ADDIU: begin
        ctrl_o.op = XOP_ADD; ctrl_o.use_imm = 1'b1;
        ctrl_o.imm_signed = 1'b1; ctrl_o.legal = 1'b1;
      end
      OPC_ANDI: begin
        ctrl_o.op = XOP_AND; ctrl_o.use_imm = 1'b1; ctrl_o.legal = 1'b1;
      end
      OPC_ORI: begin
        ctrl_o.op = XOP_OR; ctrl_o.use_imm = 1'b1; ctrl_o.legal = 1'b1;
      end
      OPC_LUI: begin
        ctrl_o.op = XOP_LUI; ctrl_o.use_imm = 1'b1; ctrl_o.legal = 1'b1;
      end
      default: ;
    endcase
  end

  // Immediate operands only ever come from non-register opcodes (R7).
  always_comb begin
    if (!$isunknown(opc_i)) begin
      assert_imm_not_regform_R7: assert (!(ctrl_o.use_imm && opc_i == OPC_REG));
      assert_illegal_has_no_op_R8: assert (ctrl_o.legal || ctrl_o.op == XOP_NONE);
    end
  end
endmodule

// File: rtl/mdx_imm_ext.sv
module mdx_imm_ext
  import mdx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] ext_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] widen(input logic [IMM_W-1:0] v,
                                              input logic sgn);
    logic fill;
    fill = sgn & v[IMM_W-1];
    return {{PAD_W{fill}}, v};
  endfunction

  assign ext_o = widen(imm_i, signed_i);

  always_comb begin
    if (!$isunknown({imm_i, signed_i})) begin
      assert_zero_ext_upper_R5: assert (signed_i || ext_o[DATA_W-1:IMM_W] == '0);
      assert_sign_ext_upper_R4: assert (!signed_i ||
        (ext_o[DATA_W-1] == imm_i[IMM_W-1] &&
         (&ext_o[DATA_W-1:IMM_W] || ~|ext_o[DATA_W-1:IMM_W])));
      assert_low_kept_R4: assert (ext_o[IMM_W-1:0] == imm_i);
    end
  end
endmodule

// File: rtl/mdx_shifter.sv
module mdx_shifter #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              right_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] dout_o
);
  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [DATA_W-1:0] stg [0:AMT_W];
  logic              fill;

  // Left shifts run through the right-shift ladder on a bit-reversed word.
  assign stg[0] = right_i ? din_i : flip(din_i);
  assign fill   = right_i & arith_i & din_i[DATA_W-1];

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{STEP{fill}}, stg[k][DATA_W-1:STEP]} : stg[k];
  end

  assign dout_o = right_i ? stg[AMT_W] : flip(stg[AMT_W]);

  always_comb begin
    if (!$isunknown({din_i, amt_i, right_i, arith_i})) begin
      assert_zero_dist_passes_R3: assert (amt_i != '0 || dout_o == din_i);
      assert_arith_keeps_sign_R3: assert (!(right_i && arith_i) ||
                                          dout_o[DATA_W-1] == din_i[DATA_W-1]);
      assert_left_low_zero_R3: assert (right_i || amt_i == '0 || dout_o[0] == 1'b0);
    end
  end
endmodule

// File: rtl/mdx_alu.sv
module mdx_alu
  import mdx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  xop_e              op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] sh_src_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int LOW_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [DATA_W-1:0] sub_wrap(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x + ~y + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  logic [DATA_W-1:0] sh_out;
  logic              sh_right, sh_arith;

  assign sh_right = (op_i == XOP_SRL) || (op_i == XOP_SRA);
  assign sh_arith = (op_i == XOP_SRA);

  mdx_shifter #(.DATA_W(DATA_W), .AMT_W(SHAMT_W)) u_shift (
    .din_i  (sh_src_i),
    .amt_i  (shamt_i),
    .right_i(sh_right),
    .arith_i(sh_arith),
    .dout_o (sh_out)
  );

  always_comb begin
    unique case (op_i)
      XOP_ADD: res_o = add_wrap(a_i, b_i);
      XOP_SUB: res_o = sub_wrap(a_i, b_i);
      XOP_AND: res_o = a_i & b_i;
      XOP_OR:  res_o = a_i | b_i;
      XOP_XOR: res_o = a_i ^ b_i;
      XOP_NOR: res_o = ~(a_i | b_i);
      XOP_SLL, XOP_SRL, XOP_SRA: res_o = sh_out;
      XOP_LUI: res_o = {imm_i, {LOW_W{1'b0}}};
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i})) begin
      assert_sub_inverts_add_R1: assert (op_i != XOP_SUB || res_o + b_i == a_i);
      assert_lui_low_zero_R6: assert (op_i != XOP_LUI || res_o[LOW_W-1:0] == '0);
    end
  end
endmodule

// File: rtl/mdx_exec_unit.sv
module mdx_exec_unit
  import mdx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  src_a_i,
  input  logic [DATA_W-1:0]  src_b_i,
  output logic [DATA_W-1:0]  result_o,
  output logic [IDX_W-1:0]   dest_idx_o,
  output logic               wr_en_o,
  output logic               illegal_o
);
  logic [OPC_W-1:0]   f_opc;
  logic [IDX_W-1:0]   f_rt, f_rd;
  logic [SHAMT_W-1:0] f_shamt;
  logic [5:0]         f_fn;
  logic [IMM_W-1:0]   f_imm;

  assign f_opc   = instr_i[31:26];
  assign f_rt    = instr_i[20:16];
  assign f_rd    = instr_i[15:11];
  assign f_shamt = instr_i[10:6];
  assign f_fn    = instr_i[5:0];
  assign f_imm   = instr_i[15:0];

  xctrl_t            ctrl;
  logic [DATA_W-1:0] imm_ext, opnd_b, alu_res;

  mdx_decoder u_dec (.opc_i(f_opc), .fn_i(f_fn), .ctrl_o(ctrl));

  mdx_imm_ext #(.DATA_W(DATA_W)) u_ext (
    .imm_i(f_imm), .signed_i(ctrl.imm_signed), .ext_o(imm_ext)
  );

  assign opnd_b = ctrl.use_imm ? imm_ext : src_b_i;

  mdx_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (ctrl.op),
    .a_i     (src_a_i),
    .b_i     (opnd_b),
    .sh_src_i(src_b_i),
    .imm_i   (f_imm),
    .shamt_i (f_shamt),
    .res_o   (alu_res)
  );

  assign wr_en_o    = ctrl.legal;
  assign illegal_o  = ~ctrl.legal;
  assign result_o   = ctrl.legal ? alu_res : '0;
  assign dest_idx_o = !ctrl.legal ? '0 : (ctrl.dest_is_rd ? f_rd : f_rt);

  always_comb begin
    if (!$isunknown(instr_i)) begin
      assert_write_xor_illegal_R7: assert (wr_en_o ^ illegal_o);
      assert_illegal_quiet_R8: assert (!illegal_o ||
                                       (result_o == '0 && dest_idx_o == '0));
      assert_regform_dest_R7: assert (!(wr_en_o && f_opc == OPC_REG) ||
                                      dest_idx_o == instr_i[15:11]);
      assert_immform_dest_R7: assert (!(wr_en_o && f_opc != OPC_REG) ||
                                      dest_idx_o == instr_i[20:16]);
    end
  end
endmodule

// File: tb/mdx_exec_unit_test.sv
module mdx_exec_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] instr, a, b, res;
  logic [4:0]  dst;
  logic        we, ill;
  int checks = 0, fails = 0;
  bit done = 0;

  mdx_exec_unit uut (
    .instr_i(instr), .src_a_i(a), .src_b_i(b),
    .result_o(res), .dest_idx_o(dst), .wr_en_o(we), .illegal_o(ill)
  );

  // Behavioural model, written from the requirements.
  task automatic model(input logic [31:0] w, input logic [31:0] x,
                       input logic [31:0] y, output logic [31:0] r,
                       output logic [4:0] d, output logic e, output string tag);
    int op, fn, sh;
    longint sx;
    op = int'(w[31:26]); fn = int'(w[5:0]); sh = int'(w[10:6]);
    e = 1; r = 0; d = 0; tag = "R8";
    if (op == 0) begin
      d = w[15:11];
      case (fn)
        'h21: begin r = 32'(longint'(x) + longint'(y)); tag = "R1"; end
        'h23: begin r = 32'(longint'(x) - longint'(y)); tag = "R1"; end
        'h25: begin r = x | y; tag = "R2"; end
        'h26: begin r = x ^ y; tag = "R2"; end
        'h27: begin r = ~(x | y); tag = "R2"; end
        'h00: begin r = y << sh; tag = "R3"; end
        'h02: begin r = y >> sh; tag = "R3"; end
        'h03: begin r = 32'($signed(y) >>> sh); tag = "R3"; end
        default: e = 0;
      endcase
    end else begin
      d = w[20:16];
      sx = longint'($signed(w[15:0]));
      case (op)
        'h09: begin r = 32'(longint'(x) + sx); tag = "R4"; end
        'h0C: begin r = x & {16'h0, w[15:0]}; tag = "R5"; end
        'h0D: begin r = x | {16'h0, w[15:0]}; tag = "R5"; end
        'h0F: begin r = {w[15:0], 16'h0}; tag = "R6"; end
        default: e = 0;
      endcase
    end
    if (!e) begin r = 0; d = 0; end
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] x,
                       input logic [31:0] y);
    logic [31:0] er; logic [4:0] ed; logic ee; string tag;
    @(posedge clk);
    instr = w; a = x; b = y;
    model(w, x, y, er, ed, ee, tag);
    @(negedge clk);
    checks++;
    if (res !== er) begin
      fails++;
      $display("FAIL %s result instr=%h got %h exp %h", tag, w, res, er);
    end
    checks++;
    if (dst !== ed || we !== ee || ill !== !ee) begin
      fails++;
      $display("FAIL R7/R8 ctl instr=%h got d=%0d we=%b il=%b exp d=%0d we=%b il=%b",
               w, dst, we, ill, ed, ee, !ee);
    end
  endtask

  function automatic logic [31:0] rform(int fn, int rd, int sh);
    return {6'h0, 5'd3, 5'd4, 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] iform(int op, int rt, logic [15:0] imm);
    return {6'(op), 5'd7, 5'(rt), imm};
  endfunction

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    instr = 32'hFFFF_FFFF; a = 0; b = 0;
    repeat (2) @(posedge clk);
    rst = 0;
    // Reset-state / R8: all-ones word is illegal
    @(negedge clk);
    checks++;
    if (we !== 0 || ill !== 1) begin
      fails++; $display("FAIL R8 initial we=%b il=%b exp 0 1", we, ill);
    end
    // R1 wrap
    apply(rform('h21, 9, 0), 32'hFFFF_FFFF, 32'h2);
    apply(rform('h23, 10, 5), 32'h0, 32'h1);
    // R2
    apply(rform('h25, 11, 0), 32'hF0F0_0000, 32'h0000_0F0F);
    apply(rform('h26, 12, 0), 32'hAAAA_5555, 32'hFFFF_0000);
    apply(rform('h27, 13, 0), 32'h1234_0000, 32'h0000_5678);
    // R3 boundaries, rs ignored
    apply(rform('h00, 14, 0), 32'hDEAD_BEEF, 32'h8000_0001);
    apply(rform('h00, 14, 31), 32'h0, 32'h8000_0001);
    apply(rform('h02, 15, 31), 32'h5, 32'h8000_0000);
    apply(rform('h03, 16, 31), 32'h5, 32'h8000_0000);
    apply(rform('h03, 16, 4), 32'h0, 32'h7000_0000);
    // R4 sign extension
    apply(iform('h09, 17, 16'hFFFF), 32'h0, 32'h0);
    apply(iform('h09, 18, 16'h7FFF), 32'hFFFF_FFFF, 32'h0);
    // R5 zero extension
    apply(iform('h0C, 19, 16'h8001), 32'hFFFF_FFFF, 32'h0);
    apply(iform('h0D, 20, 16'hFFFF), 32'h0, 32'h0);
    // R6 rs ignored
    apply(iform('h0F, 21, 16'hDEAD), 32'hFFFF_FFFF, 32'h0);
    // R8 neighbours
    apply(rform('h20, 9, 0), 32'h1, 32'h1);
    apply(rform('h01, 9, 0), 32'h1, 32'h1);
    apply(rform('h24, 9, 0), 32'h1, 32'h1);
    apply(iform('h08, 9, 16'h1), 32'h1, 32'h1);
    apply(iform('h0E, 9, 16'h1), 32'h1, 32'h1);
    apply(iform('h23, 9, 16'h1), 32'h1, 32'h1);
    // Random sweep over every requirement R1..R8
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] w;
      int pick;
      w = $urandom;
      pick = int'($urandom_range(0, 13));
      case (pick)
        0: w[31:26] = 6'h09;
        1: w[31:26] = 6'h0C;
        2: w[31:26] = 6'h0D;
        3: w[31:26] = 6'h0F;
        4: ;
        default: begin
          w[31:26] = 6'h00;
          case (pick)
            5: w[5:0] = 6'h21; 6: w[5:0] = 6'h23; 7: w[5:0] = 6'h25;
            8: w[5:0] = 6'h26; 9: w[5:0] = 6'h27; 10: w[5:0] = 6'h00;
            11: w[5:0] = 6'h02; 12: w[5:0] = 6'h03; default: ;
          endcase
        end
      endcase
      apply(w, $urandom, $urandom);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule